// File: doc/BRIEF.md
# SPI FPGA Configuration Sequencer

This block is an SPI master that programs a target FPGA through that device's slave SPI configuration port. A single start pulse launches a fixed script: the block reads the target's identifier and compares it with the two identifiers it supports. It then sends three preparation commands, and polls the target's status word until the configuration memory reports that it has been erased. After that it streams the configuration image, closes the write session, and reads status once more to learn whether the target finished configuring.

The image comes from a byte stream with a valid/ready handshake, and its byte count is sampled at start. The block never stores the image. Each byte is accepted only at the moment it is due on the wire, and the serial clock stops low while the source has nothing to offer. When the run ends, the block drops the busy flag and raises exactly one of three results: success, not-done, or a 2-bit error code.

Top module: `spi_cfg_loader`

## Requirements
- R1: A start with an image length of zero ends the run with error code 3 (empty image), and chip select never goes low.
- R2: The first frame reads the identifier. It is 16 bytes long: opcode 0x07 followed by seven 0x00 bytes, then eight read bytes sent as 0x00. The identifier is read bytes 4 to 7 (frame bytes 12 to 15), first byte most significant.
- R3: Only the identifiers 0xC2088080 and 0xC2048080 are accepted. Any other value ends the run with error code 1 (bad ID), and no further frame is sent.
- R4: After a good identifier, the block sends three 4-byte frames, each made of the opcode and three 0x00 bytes. The order is 0x71 (refresh), then 0x4A (write enable), then 0x70 (erase).
- R5: After the erase frame, the block sends status frames of the same shape as R2 but with opcode 0x09. It keeps polling until the status word equals exactly 0x00010000. Successive polls are at least POLL_MS milliseconds of system clock apart, counted from the end of one poll frame to the start of the next.
- R6: If POLL_LIMIT polls pass without the exact erased value, the run ends with error code 2 (timeout), and no image frame is sent.
- R7: The image goes out in one chip-select frame of length+8 bytes: 0x41, three 0xFF bytes, the image bytes in order, then four 0x00 bytes.
- R8: After the image, the block sends a 4-byte 0x4F frame and then a 0x09 status read. The run reports success if bit 14 (mask 0x00004000) of that word is set, and not-done otherwise. Both outcomes leave the error code at 0.
- R9: The serial clock idles low. MOSI is stable while the clock is high, and bits go most significant first. Chip select stays high for at least one serial clock period (2*CLK_DIV system cycles) between frames.
- R10: img_ready is high only during the image-data bytes of the image frame. While it waits for a valid byte, the serial clock stays low.
- R11: busy rises on the cycle after start and stays high until a result is set. At that point busy falls and exactly one of ok, not_done, or a non-zero err_code is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse to begin a configuration run |
| img_len | input | LEN_W | Image size in bytes, sampled at start |
| img_data | input | 8 | Image byte |
| img_valid | input | 1 | Image byte is offered |
| img_ready | output | 1 | Image byte is taken this cycle when valid |
| sclk | output | 1 | SPI serial clock (mode 0) |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data to target |
| miso | input | 1 | SPI data from target |
| busy | output | 1 | Run in progress |
| ok | output | 1 | Target reported configuration complete |
| not_done | output | 1 | Run finished but completion bit clear |
| err_code | output | 2 | 0 none, 1 bad ID, 2 erase timeout, 3 empty image |

## Verification
Two activities can fall in the same cycle. The first is the image source's handshake, which can coincide with the end of the shifter's previous byte. The second is a status word being judged in the same cycle that the poll counter reaches its limit. The bench offers image bytes with a stalling valid pattern so that valid returns exactly when the block is ready, and it checks that every byte appears once and in order inside the single image frame. A timeout run drives the poll count to its last allowed value, and the bench judges it by the frame list and the error code.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_ID      = 2'd1,
    ERR_TIMEOUT = 2'd2,
    ERR_EMPTY   = 2'd3
  } err_t;

  typedef enum logic [2:0] {
    ST_ID, ST_REF, ST_WEN, ST_ERASE, ST_POLL, ST_IMG, ST_WDIS, ST_FIN
  } step_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_CHECK, PH_FRAME, PH_GAP, PH_WAIT
  } phase_t;

  localparam logic [31:0] ID_A       = 32'hC208_8080;
  localparam logic [31:0] ID_B       = 32'hC204_8080;
  localparam logic [31:0] ERASED_VAL = 32'h0001_0000;
  localparam int          DONE_BIT   = 14;

  function automatic logic [7:0] step_opcode(step_t s);
    case (s)
      ST_ID:    return 8'h07;
      ST_REF:   return 8'h71;
      ST_WEN:   return 8'h4A;
      ST_ERASE: return 8'h70;
      ST_IMG:   return 8'h41;
      ST_WDIS:  return 8'h4F;
      default:  return 8'h09;
    endcase
  endfunction

  function automatic logic step_reads(step_t s);
    return (s == ST_ID) || (s == ST_POLL) || (s == ST_FIN);
  endfunction
endpackage

// File: rtl/cfg_spi_shifter.sv
module cfg_spi_shifter #(
  parameter int CLK_DIV = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic [7:0] tx,
  output logic       done,
  output logic [7:0] rx,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso
);
  localparam int CW = $clog2(CLK_DIV) + 1;

  logic          active;
  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      bitn   <= '0;
      sh     <= '0;
      rx     <= '0;
      sclk   <= 1'b0;
      mosi   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (go) begin
          active <= 1'b1;
          sh     <= tx;
          mosi   <= tx[7];
          cnt    <= '0;
          bitn   <= '0;
        end
      end else if (cnt == CW'(CLK_DIV - 1)) begin
        cnt <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
          rx   <= {rx[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bitn == 3'd7) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            bitn <= bitn + 3'd1;
            sh   <= {sh[6:0], 1'b0};
            mosi <= sh[6];
          end
        end
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  // R9
  mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(mosi));

  // R9
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!active && !go) |=> !sclk);
endmodule

// File: rtl/cfg_wait_timer.sv
module cfg_wait_timer #(
  parameter int WAIT_CYC = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic kick,
  output logic expired
);
  localparam int TW = $clog2(WAIT_CYC + 1);

  logic [TW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      run     <= 1'b0;
      expired <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (kick) begin
        run <= 1'b1;
        cnt <= '0;
      end else if (run) begin
        if (cnt == TW'(WAIT_CYC - 1)) begin
          run     <= 1'b0;
          expired <= 1'b1;
        end else begin
          cnt <= cnt + TW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/spi_cfg_loader.sv
module spi_cfg_loader
  import cfg_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int CLK_DIV    = 2,
  parameter int CLK_HZ     = 50_000_000,
  parameter int POLL_MS    = 10,
  parameter int POLL_LIMIT = 500
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] img_len,
  input  logic [7:0]       img_data,
  input  logic             img_valid,
  output logic             img_ready,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi,
  input  logic             miso,
  output logic             busy,
  output logic             ok,
  output logic             not_done,
  output logic [1:0]       err_code
);
  localparam int CNT_W    = LEN_W + 1;
  localparam int MS_TICKS = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;
  localparam int WAIT_CYC = POLL_MS * MS_TICKS;
  localparam int GAP_CYC  = 2 * CLK_DIV;
  localparam int GW       = $clog2(GAP_CYC + 1);
  localparam int PW       = $clog2(POLL_LIMIT + 1);

  phase_t           phase;
  step_t            step, nxt_step;
  logic [CNT_W-1:0] idx, frame_len;
  logic [LEN_W-1:0] len_q;
  logic             launch;
  logic [31:0]      rx_word;
  logic [PW-1:0]    poll_cnt;
  logic [GW-1:0]    gap_cnt;
  logic             gap_done, go_frame, go_wait, fin, fin_ok, fin_nd;
  err_t             fin_err;
  logic             need_img, eng_go, eng_done, tmr_done;
  logic [7:0]       tx_byte, eng_rx;

  always_comb begin
    if (step == ST_IMG)        frame_len = CNT_W'(len_q) + CNT_W'(8);
    else if (step_reads(step)) frame_len = CNT_W'(16);
    else                       frame_len = CNT_W'(4);
  end

  assign need_img  = (step == ST_IMG) && (idx >= CNT_W'(4)) &&
                     (idx < CNT_W'(len_q) + CNT_W'(4));
  assign img_ready = (phase == PH_FRAME) && launch && need_img;
  assign eng_go    = (phase == PH_FRAME) && launch && (!need_img || img_valid);
  assign gap_done  = (phase == PH_GAP) && (gap_cnt == GW'(GAP_CYC - 1));

  always_comb begin
    if (idx == '0)     tx_byte = step_opcode(step);
    else if (idx < CNT_W'(4)) tx_byte = (step == ST_IMG) ? 8'hFF : 8'h00;
    else if (need_img) tx_byte = img_data;
    else               tx_byte = 8'h00;
  end

  always_comb begin
    nxt_step = step;
    go_frame = 1'b0;
    go_wait  = 1'b0;
    fin      = 1'b0;
    fin_ok   = 1'b0;
    fin_nd   = 1'b0;
    fin_err  = ERR_NONE;
    case (step)
      ST_ID: begin
        if (rx_word == ID_A || rx_word == ID_B) begin
          nxt_step = ST_REF;
          go_frame = 1'b1;
        end else begin
          fin     = 1'b1;
          fin_err = ERR_ID;
        end
      end
      ST_REF:   begin nxt_step = ST_WEN;   go_frame = 1'b1; end
      ST_WEN:   begin nxt_step = ST_ERASE; go_frame = 1'b1; end
      ST_ERASE: begin nxt_step = ST_POLL;  go_frame = 1'b1; end
      ST_POLL: begin
        if (rx_word == ERASED_VAL) begin
          nxt_step = ST_IMG;
          go_frame = 1'b1;
        end else if (poll_cnt == PW'(POLL_LIMIT - 1)) begin
          fin     = 1'b1;
          fin_err = ERR_TIMEOUT;
        end else begin
          go_wait = 1'b1;
        end
      end
      ST_IMG:  begin nxt_step = ST_WDIS; go_frame = 1'b1; end
      ST_WDIS: begin nxt_step = ST_FIN;  go_frame = 1'b1; end
      default: begin
        fin    = 1'b1;
        fin_ok = rx_word[DONE_BIT];
        fin_nd = !rx_word[DONE_BIT];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      step     <= ST_ID;
      idx      <= '0;
      len_q    <= '0;
      launch   <= 1'b0;
      rx_word  <= '0;
      poll_cnt <= '0;
      gap_cnt  <= '0;
      cs_n     <= 1'b1;
      busy     <= 1'b0;
      ok       <= 1'b0;
      not_done <= 1'b0;
      err_code <= ERR_NONE;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          busy     <= 1'b1;
          ok       <= 1'b0;
          not_done <= 1'b0;
          err_code <= ERR_NONE;
          len_q    <= img_len;
          poll_cnt <= '0;
          phase    <= PH_CHECK;
        end
        PH_CHECK: begin
          if (len_q == '0) begin
            err_code <= ERR_EMPTY;
            busy     <= 1'b0;
            phase    <= PH_IDLE;
          end else begin
            step   <= ST_ID;
            cs_n   <= 1'b0;
            idx    <= '0;
            launch <= 1'b1;
            phase  <= PH_FRAME;
          end
        end
        PH_FRAME: begin
          if (eng_done) begin
            rx_word <= {rx_word[23:0], eng_rx};
            if (idx == frame_len - CNT_W'(1)) begin
              cs_n    <= 1'b1;
              gap_cnt <= '0;
              phase   <= PH_GAP;
            end else begin
              idx    <= idx + CNT_W'(1);
              launch <= 1'b1;
            end
          end else if (eng_go) begin
            launch <= 1'b0;
          end
        end
        PH_GAP: begin
          gap_cnt <= gap_cnt + GW'(1);
          if (gap_done) begin
            step <= nxt_step;
            if (go_frame) begin
              cs_n   <= 1'b0;
              idx    <= '0;
              launch <= 1'b1;
              phase  <= PH_FRAME;
            end else if (go_wait) begin
              poll_cnt <= poll_cnt + PW'(1);
              phase    <= PH_WAIT;
            end else begin
              busy     <= 1'b0;
              ok       <= fin_ok;
              not_done <= fin_nd;
              err_code <= fin_err;
              phase    <= PH_IDLE;
            end
          end
        end
        default: if (tmr_done) begin
          cs_n   <= 1'b0;
          idx    <= '0;
          launch <= 1'b1;
          phase  <= PH_FRAME;
        end
      endcase
    end
  end

  cfg_spi_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst(rst), .go(eng_go), .tx(tx_byte), .done(eng_done),
    .rx(eng_rx), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  cfg_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_wait (
    .clk(clk), .rst(rst), .kick(gap_done && go_wait), .expired(tmr_done)
  );

  // R10
  ready_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    img_ready |-> (!cs_n && !sclk));

  // R9
  sclk_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> !cs_n);

  // R11
  result_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ok, not_done, err_code != 2'd0}) && !(busy && (ok || not_done)));

  // R6
  poll_bound_chk: assert property (@(posedge clk) disable iff (rst)
    poll_cnt < PW'(POLL_LIMIT));

  // R1
  empty_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CHECK && len_q == '0) |=> (cs_n && err_code == 2'd3));
endmodule

// File: tb/spi_cfg_loader_test.sv
module spi_cfg_loader_test;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W      = 12;
  localparam int CLK_DIV    = 2;
  localparam int CLK_HZ     = 10_000;
  localparam int POLL_MS    = 10;
  localparam int POLL_LIMIT = 4;
  localparam int WAIT_CYC   = POLL_MS * (CLK_HZ / 1000);

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [LEN_W-1:0] img_len = '0;
  logic [7:0] img_data = 8'h00;
  logic img_valid = 1'b0;
  logic img_ready, sclk, cs_n, mosi, busy, ok, not_done;
  logic miso;
  logic [1:0] err_code;

  int checks = 0, errors = 0, cyc = 0;

  spi_cfg_loader #(.LEN_W(LEN_W), .CLK_DIV(CLK_DIV), .CLK_HZ(CLK_HZ),
                   .POLL_MS(POLL_MS), .POLL_LIMIT(POLL_LIMIT)) uut (
    .clk(clk), .rst(rst), .start(start), .img_len(img_len),
    .img_data(img_data), .img_valid(img_valid), .img_ready(img_ready),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso), .busy(busy),
    .ok(ok), .not_done(not_done), .err_code(err_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  // target model: scenario settings
  logic [31:0] id_val, final_st;
  int clear_after, polls_seen;
  bit img_seen, stall_mode;

  // target model: frame capture
  int bitpos;
  logic [7:0] shreg, cur_op;
  logic [7:0] cur_bytes[$];
  logic [7:0] rec_bytes[$];
  int rec_lens[$], rec_start[$], rec_end[$];
  int cs_rise_cyc;
  logic miso_drv = 1'b0;
  assign miso = miso_drv;

  function automatic logic resp_bit(int n);
    logic [31:0] w;
    if (n < 96 || n > 127) return 1'b0;
    if (cur_op == 8'h07) w = id_val;
    else if (cur_op == 8'h09)
      w = img_seen ? final_st : ((polls_seen < clear_after) ? 32'h0001_0001 : 32'h0001_0000);
    else w = 32'h0;
    return w[127 - n];
  endfunction

  task automatic check(bit cond, string req, string what, longint act, longint exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge cs_n) if (!rst) begin
    // R9 gap since previous frame
    check((cyc - cs_rise_cyc) >= 2*CLK_DIV, "R9", "cs_n high gap", cyc - cs_rise_cyc, 2*CLK_DIV);
    bitpos = 0; cur_op = 8'h00; cur_bytes.delete();
    rec_start.push_back(cyc);
    miso_drv = resp_bit(0);
  end

  always @(posedge sclk) if (!cs_n) begin
    shreg = {shreg[6:0], mosi};
    bitpos++;
    if (bitpos % 8 == 0) begin
      cur_bytes.push_back(shreg);
      if (bitpos == 8) cur_op = shreg;
    end
  end

  always @(negedge sclk) if (!cs_n) miso_drv = resp_bit(bitpos);

  always @(posedge cs_n) if (!rst) begin
    cs_rise_cyc = cyc;
    foreach (cur_bytes[i]) rec_bytes.push_back(cur_bytes[i]);
    rec_lens.push_back(cur_bytes.size());
    rec_end.push_back(cyc);
    if (cur_op == 8'h09 && !img_seen) polls_seen++;
    if (cur_op == 8'h41) img_seen = 1'b1;
  end

  // image source
  logic [7:0] img_q[$];
  always @(posedge clk) if (img_valid && img_ready) void'(img_q.pop_front());
  always @(negedge clk) begin
    if (img_q.size() > 0 && (!stall_mode || (cyc % 5) > 2)) begin
      img_valid = 1'b1; img_data = img_q[0];
    end else begin
      img_valid = 1'b0; img_data = 8'h00;
    end
  end

  // per-clock monitor
  always @(negedge clk) if (!rst) begin
    // R10
    if (img_ready && (cs_n || sclk || cur_op != 8'h41)) begin
      errors++; checks++;
      $display("FAIL R10 img_ready outside image data: actual cs_n=%0b sclk=%0b expected 0 0", cs_n, sclk);
    end
    // R11
    if (busy && (ok || not_done || err_code != 2'd0)) begin
      errors++; checks++;
      $display("FAIL R11 result while busy: actual %0b%0b%0d expected 000", ok, not_done, err_code);
    end
  end

  // expected frames
  logic [7:0] exp_bytes[$];
  int exp_lens[$];
  logic [7:0] img_copy[$];

  task automatic exp_short(logic [7:0] op);
    exp_bytes.push_back(op);
    repeat (3) exp_bytes.push_back(8'h00);
    exp_lens.push_back(4);
  endtask
  task automatic exp_read(logic [7:0] op);
    exp_bytes.push_back(op);
    repeat (15) exp_bytes.push_back(8'h00);
    exp_lens.push_back(16);
  endtask
  task automatic exp_image();
    exp_bytes.push_back(8'h41);
    repeat (3) exp_bytes.push_back(8'hFF);
    foreach (img_copy[i]) exp_bytes.push_back(img_copy[i]);
    repeat (4) exp_bytes.push_back(8'h00);
    exp_lens.push_back(img_copy.size() + 8);
  endtask

  function automatic string req_of(logic [7:0] op);
    case (op)
      8'h07: return "R2";
      8'h71, 8'h4A, 8'h70: return "R4";
      8'h41: return "R7";
      8'h4F: return "R8";
      default: return "R5";
    endcase
  endfunction

  task automatic compare_frames(string cnt_req);
    int p = 0;
    check(rec_lens.size() == exp_lens.size(), cnt_req, "frame count", rec_lens.size(), exp_lens.size());
    for (int f = 0; f < exp_lens.size() && f < rec_lens.size(); f++) begin
      bit same = (rec_lens[f] == exp_lens[f]);
      for (int b = 0; same && b < exp_lens[f]; b++)
        if (rec_bytes[p+b] !== exp_bytes[p+b]) same = 0;
      check(same, req_of(exp_bytes[p]), $sformatf("frame %0d content", f),
            rec_lens[f], exp_lens[f]);
      p += exp_lens[f];
    end
  endtask

  task automatic run_case(logic [31:0] id, int clr, logic [31:0] fst, int len, bit stall);
    id_val = id; clear_after = clr; final_st = fst; stall_mode = stall;
    polls_seen = 0; img_seen = 0;
    rec_bytes.delete(); rec_lens.delete(); rec_start.delete(); rec_end.delete();
    exp_bytes.delete(); exp_lens.delete(); img_copy.delete(); img_q.delete();
    for (int i = 0; i < len; i++) begin
      img_copy.push_back(8'((i * 37 + len * 11 + 5) & 255));
      img_q.push_back(8'((i * 37 + len * 11 + 5) & 255));
    end
    @(negedge clk);
    img_len = LEN_W'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R11 busy on the cycle after start
    check(busy == 1'b1, "R11", "busy after start", busy, 1);
    for (int w = 0; w < 60000 && busy; w++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cs_rise_cyc = -100;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cs_n && !sclk && !busy && !ok && !not_done && err_code == 0 && !img_ready,
          "R11", "reset state", {cs_n, sclk, busy, ok, not_done, img_ready}, 6'b100000);

    // normal run, two non-exact polls, done bit set
    run_case(32'hC208_8080, 2, 32'h0000_4000, 20, 0);
    exp_read(8'h07); exp_short(8'h71); exp_short(8'h4A); exp_short(8'h70);
    repeat (3) exp_read(8'h09);
    exp_image(); exp_short(8'h4F); exp_read(8'h09);
    compare_frames("R5");
    check(ok && !not_done && err_code == 0, "R8", "success result", {ok, not_done, err_code}, 4'b1000);
    for (int f = 4; f < 6; f++)
      check(rec_start[f+1] - rec_end[f] >= WAIT_CYC, "R5", "poll spacing",
            rec_start[f+1] - rec_end[f], WAIT_CYC);

    // second ID, stalling source, done bit clear
    run_case(32'hC204_8080, 0, 32'hFFFF_BFFF, 13, 1);
    exp_read(8'h07); exp_short(8'h71); exp_short(8'h4A); exp_short(8'h70);
    exp_read(8'h09); exp_image(); exp_short(8'h4F); exp_read(8'h09);
    compare_frames("R10");
    check(!ok && not_done && err_code == 0, "R8", "not-done result", {ok, not_done, err_code}, 4'b0100);

    // one-byte image
    run_case(32'hC208_8080, 0, 32'h0000_4000, 1, 1);
    exp_read(8'h07); exp_short(8'h71); exp_short(8'h4A); exp_short(8'h70);
    exp_read(8'h09); exp_image(); exp_short(8'h4F); exp_read(8'h09);
    compare_frames("R7");
    check(ok && err_code == 0, "R7", "one-byte image result", {ok, err_code}, 3'b100);

    // bad identifier
    run_case(32'hC208_8081, 0, 32'h0000_4000, 8, 0);
    exp_read(8'h07);
    compare_frames("R3");
    check(err_code == 2'd1 && !ok && !not_done, "R3", "bad id error", err_code, 1);

    // empty image
    run_case(32'hC208_8080, 0, 32'h0000_4000, 0, 0);
    compare_frames("R1");
    check(err_code == 2'd3 && !busy, "R1", "empty image error", err_code, 3);

    // erase never completes
    run_case(32'hC204_8080, 1000, 32'h0000_4000, 6, 0);
    exp_read(8'h07); exp_short(8'h71); exp_short(8'h4A); exp_short(8'h70);
    repeat (POLL_LIMIT) exp_read(8'h09);
    compare_frames("R6");
    check(err_code == 2'd2 && !ok && !not_done, "R6", "timeout error", err_code, 2);

    // a fresh run after an error clears the result
    run_case(32'hC208_8080, 0, 32'h0000_4000, 3, 0);
    check(ok && err_code == 0, "R11", "result after prior error", {ok, err_code}, 3'b100);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule